// File: doc/BRIEF.md
# Load/Store Port Handshake Monitor

This block watches one load/store request port between a compute unit and a small cache or buffer, without driving anything on that port. A transaction on this port does not complete the moment it is issued. The requester raises a load or store request. The responder holds a busy flag for as long as the transaction is open. The address acknowledge or the address exception, and then the load-valid or store-valid pulse, each close a part of the transaction, and each has its own rule for when busy may drop. The monitor follows the transaction phase cycle by cycle and checks every handshake rule as it goes.

Each rule owns one sticky error flag. A flag is set in the cycle after the rule is first broken, stays set until reset, and all flags are ORed into one summary output. A kill input abandons the open transaction. The monitor then stays quiet until busy is low again, and after that it picks up tracking from idle. Data values are not checked. Only the control lines, the address and busy are observed.

Top module: `ldst_port_monitor`

## Requirements
- R1: A request that starts while busy was high on the previous cycle sets flag bit 0. This bit is also set by a request of the other kind during an open transaction, and by any request in the cycle after a store-valid pulse.
- R2: Load request and store request high on the same cycle sets flag bit 1. When both are high at the start of a transaction, the transaction is treated as a load.
- R3: Busy must be high from the first cycle of a request until the cycle that ends the transaction. A low busy before that cycle sets flag bit 2.
- R4: Once address-valid has been seen in a transaction, address-valid must stay high and the address must stay unchanged on every later cycle where busy is high. A change sets flag bit 3.
- R5: Address acknowledge, and also address exception, high on two cycles in a row sets flag bit 4.
- R6: Address acknowledge and address exception high together, either one after an acknowledge earlier in the same transaction, or either one outside an open transaction, sets flag bit 5.
- R7: An address exception with busy still high in that same cycle sets flag bit 6. The exception ends the transaction.
- R8: During a load, a load-valid pulse with busy still high sets flag bit 7. Load-valid high on two cycles in a row also sets bit 7. Load-valid ends the load.
- R9: During a store, a store-valid pulse before the address acknowledge was seen on an earlier cycle sets flag bit 8. Store-valid high on two cycles in a row also sets bit 8.
- R10: Busy must be low on the cycle after a store-valid pulse. If it is high there, flag bit 9 is set.
- R11: Load-valid during a store, or store-valid during a load, sets flag bit 10.
- R12: While kill is high, and afterwards until busy is seen low, no flag is set. Tracking then restarts from idle.
- R13: Flags are low after a synchronous active-high reset, keep their value until the next reset, and err_any is high exactly when any flag is high. Flags appear one clock after the offending cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_ld | input | 1 | Load request from the requester |
| req_st | input | 1 | Store request from the requester |
| addr_vld | input | 1 | Address-valid flag from the requester |
| addr | input | ADDR_W | Request address |
| addr_ack | input | 1 | Address accepted pulse from the responder |
| addr_exc | input | 1 | Address exception pulse from the responder |
| ld_vld | input | 1 | Load data valid pulse from the responder |
| st_vld | input | 1 | Store data valid pulse from the requester |
| busy | input | 1 | Transaction-open flag from the responder |
| kill | input | 1 | Abort of the open transaction |
| err_flags | output | 11 | Sticky per-rule error flags, bit n set by the rule stated above |
| err_any | output | 1 | OR of all error flags |

## Verification
The kill abort and the rule checks can land on the same cycle. In that cycle an abandoned transaction may show broken handshakes, and suppression has to win. The bench drives kill together with a simultaneous acknowledge and exception under high busy, then a double request while the monitor is still waiting for busy to drop. It expects every flag to stay clear. It then runs a clean transaction and a deliberate busy violation to confirm that tracking resumed. Constrained-random legal traffic with varied address, acknowledge and data latencies must leave every flag clear. Directed single-rule violations must set exactly the one stated bit, or in the double-acknowledge case the two stated bits.

// File: rtl/ldst_mon_pkg.sv
package ldst_mon_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_STORE,
        PH_DRAIN,
        PH_KILLED
    } phase_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_LOAD,
        K_STORE
    } kind_e;

    localparam int NRULE        = 11;
    localparam int RB_REQ_BUSY  = 0;
    localparam int RB_BOTH      = 1;
    localparam int RB_BUSY_HOLD = 2;
    localparam int RB_ADDR_HOLD = 3;
    localparam int RB_PULSE     = 4;
    localparam int RB_ADDR_EXCL = 5;
    localparam int RB_EXC_BUSY  = 6;
    localparam int RB_LD_DONE   = 7;
    localparam int RB_ST_ORDER  = 8;
    localparam int RB_ST_DRAIN  = 9;
    localparam int RB_CROSS     = 10;

    // Raw per-cycle view of the watched port (address kept apart: width is a parameter)
    typedef struct packed {
        logic req_ld;
        logic req_st;
        logic addr_vld;
        logic addr_ack;
        logic addr_exc;
        logic ld_vld;
        logic st_vld;
        logic busy;
        logic kill;
    } port_obs_t;

    // Tracker state handed to the rule evaluator
    typedef struct packed {
        phase_e phase;
        kind_e  kind;
        logic   active;
        logic   addr_seen;
        logic   addr_moved;
        logic   ack_seen;
        logic   busy_q;
        logic   ack_q;
        logic   exc_q;
        logic   ld_q;
        logic   st_q;
    } track_t;

    // Transaction kind in force this cycle; an idle cycle with a request starts one
    function automatic kind_e kind_of(phase_e ph, logic rl, logic rs);
        kind_e k;
        case (ph)
            PH_LOAD:  k = K_LOAD;
            PH_STORE: k = K_STORE;
            PH_IDLE:  k = rl ? K_LOAD : (rs ? K_STORE : K_NONE);
            default:  k = K_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ldst_mon_track.sv
module ldst_mon_track
    import ldst_mon_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  port_obs_t         obs,
    input  logic [ADDR_W-1:0] addr,
    output track_t            trk
);

    phase_e            phase_q, phase_d;
    kind_e             kind;
    logic              active;
    logic              keep_ctx;
    logic              addr_seen_q, ack_seen_q;
    logic [ADDR_W-1:0] addr_q;
    logic              busy_q, ack_q, exc_q, ld_q, st_q;

    assign kind   = kind_of(phase_q, obs.req_ld, obs.req_st);
    assign active = (kind != K_NONE);

    always_comb begin
        phase_d = phase_q;
        if (obs.kill) begin
            phase_d = obs.busy ? PH_KILLED : PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_KILLED: phase_d = obs.busy ? PH_KILLED : PH_IDLE;
                PH_DRAIN:  phase_d = PH_IDLE;
                default: begin
                    if (active) begin
                        if (obs.addr_exc)
                            phase_d = PH_IDLE;
                        else if (kind == K_LOAD && obs.ld_vld)
                            phase_d = PH_IDLE;
                        else if (kind == K_STORE && obs.st_vld)
                            phase_d = PH_DRAIN;
                        else
                            phase_d = (kind == K_LOAD) ? PH_LOAD : PH_STORE;
                    end
                end
            endcase
        end
    end

    assign keep_ctx = (phase_d == PH_LOAD) || (phase_d == PH_STORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Per-transaction context: first address seen and acknowledge history
    always_ff @(posedge clk) begin
        if (rst || !keep_ctx) begin
            addr_seen_q <= 1'b0;
            ack_seen_q  <= 1'b0;
            addr_q      <= '0;
        end else begin
            if (obs.addr_vld && !addr_seen_q) begin
                addr_seen_q <= 1'b1;
                addr_q      <= addr;
            end
            if (obs.addr_ack)
                ack_seen_q <= 1'b1;
        end
    end

    // One-cycle history of the pulse lines and busy
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ack_q  <= 1'b0;
            exc_q  <= 1'b0;
            ld_q   <= 1'b0;
            st_q   <= 1'b0;
        end else begin
            busy_q <= obs.busy;
            ack_q  <= obs.addr_ack;
            exc_q  <= obs.addr_exc;
            ld_q   <= obs.ld_vld;
            st_q   <= obs.st_vld;
        end
    end

    always_comb begin
        trk.phase      = phase_q;
        trk.kind       = kind;
        trk.active     = active;
        trk.addr_seen  = addr_seen_q;
        trk.addr_moved = (addr != addr_q);
        trk.ack_seen   = ack_seen_q;
        trk.busy_q     = busy_q;
        trk.ack_q      = ack_q;
        trk.exc_q      = exc_q;
        trk.ld_q       = ld_q;
        trk.st_q       = st_q;
    end

    a_r12_kill_idle: assert property (@(posedge clk) disable iff (rst)
        (obs.kill && !obs.busy) |=> (phase_q == PH_IDLE));

    a_r10_drain_once: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DRAIN) |=> (phase_q != PH_DRAIN));

    a_r8_load_ends: assert property (@(posedge clk) disable iff (rst)
        (!obs.kill && kind == K_LOAD && obs.ld_vld) |=> (phase_q == PH_IDLE));

    a_r9_store_drains: assert property (@(posedge clk) disable iff (rst)
        (!obs.kill && kind == K_STORE && obs.st_vld && !obs.addr_exc)
        |=> (phase_q == PH_DRAIN));

endmodule

// File: rtl/ldst_mon_rules.sv
module ldst_mon_rules
    import ldst_mon_pkg::*;
(
    input  port_obs_t        obs,
    input  track_t           trk,
    output logic [NRULE-1:0] hit
);

    logic enable;
    logic any_req;
    logic any_addr_pulse;
    logic in_load, in_store;
    logic load_closing;

    assign enable         = !obs.kill && (trk.phase != PH_KILLED);
    assign any_req        = obs.req_ld || obs.req_st;
    assign any_addr_pulse = obs.addr_ack || obs.addr_exc;
    assign in_load        = (trk.kind == K_LOAD);
    assign in_store       = (trk.kind == K_STORE);
    assign load_closing   = in_load && obs.ld_vld;

    logic [NRULE-1:0] raw;

    always_comb begin
        raw = '0;

        raw[RB_REQ_BUSY] = (trk.phase == PH_IDLE  && any_req && trk.busy_q)
                        || (trk.phase == PH_DRAIN && any_req)
                        || (trk.phase == PH_LOAD  && obs.req_st)
                        || (trk.phase == PH_STORE && obs.req_ld);

        raw[RB_BOTH] = obs.req_ld && obs.req_st;

        raw[RB_BUSY_HOLD] = trk.active && !obs.busy && !obs.addr_exc && !load_closing;

        raw[RB_ADDR_HOLD] = (trk.phase == PH_LOAD || trk.phase == PH_STORE)
                         && trk.addr_seen && obs.busy
                         && (!obs.addr_vld || trk.addr_moved);

        raw[RB_PULSE] = (obs.addr_ack && trk.ack_q) || (obs.addr_exc && trk.exc_q);

        raw[RB_ADDR_EXCL] = (obs.addr_ack && obs.addr_exc)
                         || (any_addr_pulse && trk.ack_seen)
                         || (any_addr_pulse && !trk.active);

        raw[RB_EXC_BUSY] = trk.active && obs.addr_exc && obs.busy;

        raw[RB_LD_DONE] = (load_closing && obs.busy) || (obs.ld_vld && trk.ld_q);

        raw[RB_ST_ORDER] = (in_store && obs.st_vld && !trk.ack_seen)
                        || (obs.st_vld && trk.st_q);

        raw[RB_ST_DRAIN] = (trk.phase == PH_DRAIN) && obs.busy;

        raw[RB_CROSS] = (obs.ld_vld && in_store) || (obs.st_vld && in_load);
    end

    assign hit = enable ? raw : '0;

endmodule

// File: rtl/ldst_mon_sticky.sv
module ldst_mon_sticky #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hit,
    output logic [N-1:0] err_q,
    output logic         err_any
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                err_q[i] <= 1'b0;
            else if (hit[i])
                err_q[i] <= 1'b1;
        end

        a_r13_hold: assert property (@(posedge clk) disable iff (rst)
            err_q[i] |=> err_q[i]);

        a_r13_capture: assert property (@(posedge clk) disable iff (rst)
            hit[i] |=> err_q[i]);
    end

    assign err_any = |err_q;

endmodule

// File: rtl/ldst_port_monitor.sv
module ldst_port_monitor
    import ldst_mon_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_ld,
    input  logic              req_st,
    input  logic              addr_vld,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_ack,
    input  logic              addr_exc,
    input  logic              ld_vld,
    input  logic              st_vld,
    input  logic              busy,
    input  logic              kill,
    output logic [NRULE-1:0]  err_flags,
    output logic              err_any
);

    port_obs_t        obs;
    track_t           trk;
    logic [NRULE-1:0] hits;

    always_comb begin
        obs.req_ld   = req_ld;
        obs.req_st   = req_st;
        obs.addr_vld = addr_vld;
        obs.addr_ack = addr_ack;
        obs.addr_exc = addr_exc;
        obs.ld_vld   = ld_vld;
        obs.st_vld   = st_vld;
        obs.busy     = busy;
        obs.kill     = kill;
    end

    ldst_mon_track #(.ADDR_W(ADDR_W)) u_track (
        .clk  (clk),
        .rst  (rst),
        .obs  (obs),
        .addr (addr),
        .trk  (trk)
    );

    ldst_mon_rules u_rules (
        .obs (obs),
        .trk (trk),
        .hit (hits)
    );

    ldst_mon_sticky #(.N(NRULE)) u_sticky (
        .clk     (clk),
        .rst     (rst),
        .hit     (hits),
        .err_q   (err_flags),
        .err_any (err_any)
    );

    a_r12_quiet: assert property (@(posedge clk) disable iff (rst)
        kill |-> (hits == '0));

    a_r2_both: assert property (@(posedge clk) disable iff (rst)
        (req_ld && req_st && !kill && trk.phase != PH_KILLED) |=> err_flags[RB_BOTH]);

endmodule

// File: tb/ldst_port_monitor_tb.sv
module ldst_port_monitor_tb;
    import ldst_mon_pkg::*;

    localparam int AW = 16;
    localparam logic [NRULE-1:0] ONE = 1;

    logic clk = 1'b0;
    logic rst;
    logic req_ld, req_st, addr_vld, addr_ack, addr_exc, ld_vld, st_vld, busy, kill;
    logic [AW-1:0] addr;
    logic [NRULE-1:0] err_flags;
    logic err_any;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ldst_port_monitor #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .req_ld(req_ld), .req_st(req_st),
        .addr_vld(addr_vld), .addr(addr), .addr_ack(addr_ack), .addr_exc(addr_exc),
        .ld_vld(ld_vld), .st_vld(st_vld), .busy(busy), .kill(kill),
        .err_flags(err_flags), .err_any(err_any)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [NRULE-1:0] bit_of(int i);
        return ONE << i;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic quiet();
        req_ld = 0; req_st = 0; addr_vld = 0; addr_ack = 0; addr_exc = 0;
        ld_vld = 0; st_vld = 0; busy = 0; kill = 0;
    endtask

    task automatic drv(input logic rl, input logic rs, input logic av, input logic ak,
                       input logic ex, input logic lv, input logic sv, input logic b);
        req_ld = rl; req_st = rs; addr_vld = av; addr_ack = ak; addr_exc = ex;
        ld_vld = lv; st_vld = sv; busy = b;
        tick();
    endtask

    task automatic check(input string tag, input logic [NRULE-1:0] exp);
        n_chk++;
        if (err_flags !== exp || err_any !== (|exp)) begin
            n_fail++;
            $display("FAIL %s: actual flags=%h any=%b expected flags=%h any=%b",
                     tag, err_flags, err_any, exp, |exp);
        end
    endtask

    task automatic do_reset();
        quiet();
        rst = 1;
        tick();
        tick();
        rst = 0;
    endtask

    // Legal transaction built from the handshake rules
    task automatic legal_txn(input bit is_st, input bit exc, input logic [AW-1:0] a,
                             input int d_addr, input int d_ack, input int d_data);
        int k;
        bit fin;
        int ack_k;
        int dat_k;
        k = 0;
        fin = 0;
        ack_k = d_addr + d_ack;
        dat_k = ack_k + 1 + d_data;
        while (!fin) begin
            req_ld = !is_st; req_st = is_st; busy = 1;
            addr_vld = (k >= d_addr); addr = a;
            addr_ack = 0; addr_exc = 0; ld_vld = 0; st_vld = 0;
            if (k == ack_k) begin
                if (exc) begin
                    addr_exc = 1; busy = 0; fin = 1;
                end else begin
                    addr_ack = 1;
                end
            end else if (!exc && k == dat_k) begin
                if (is_st) st_vld = 1;
                else begin ld_vld = 1; busy = 0; end
                fin = 1;
            end
            tick();
            k++;
        end
        if (is_st && !exc) begin
            quiet();
            tick();
        end
    endtask

    initial begin
        quiet();
        addr = '0;
        rst = 1;
        tick();

        do_reset();
        check("R13 reset state", '0);

        // R1: request starts while busy was already high
        drv(0,0,0,0,0,0,0,1);
        drv(1,0,0,0,0,0,0,1);
        check("R1 request while busy", bit_of(0));

        do_reset();
        drv(1,1,0,0,0,0,0,1);
        check("R2 both requests", bit_of(1));

        do_reset();
        drv(1,0,0,0,0,0,0,0);
        check("R3 busy low at request", bit_of(2));

        do_reset();
        addr = 16'h0011;
        drv(1,0,1,0,0,0,0,1);
        addr = 16'h0022;
        drv(1,0,1,0,0,0,0,1);
        check("R4 address changed", bit_of(3));

        do_reset();
        addr = 16'h0005;
        drv(1,0,1,0,0,0,0,1);
        drv(1,0,1,1,0,0,0,1);
        check("R5 single acknowledge clean", '0);
        drv(1,0,1,1,0,0,0,1);
        check("R5 R6 double acknowledge", bit_of(4) | bit_of(5));

        do_reset();
        drv(1,0,1,0,0,0,0,1);
        drv(1,0,1,1,1,0,0,0);
        check("R6 acknowledge with exception", bit_of(5));

        do_reset();
        drv(1,0,1,0,0,0,0,1);
        drv(1,0,1,0,1,0,0,1);
        check("R7 busy high at exception", bit_of(6));

        do_reset();
        drv(1,0,1,0,0,0,0,1);
        drv(1,0,1,1,0,0,0,1);
        drv(1,0,1,0,0,1,0,1);
        check("R8 busy high at load valid", bit_of(7));

        do_reset();
        drv(0,1,1,0,0,0,0,1);
        drv(0,1,1,0,0,0,1,1);
        check("R9 store valid before acknowledge", bit_of(8));

        do_reset();
        drv(0,1,1,0,0,0,0,1);
        drv(0,1,1,1,0,0,0,1);
        drv(0,1,1,0,0,0,1,1);
        check("R9 store after acknowledge clean", '0);
        drv(0,0,0,0,0,0,0,1);
        check("R10 busy held after store", bit_of(9));

        do_reset();
        drv(1,0,1,0,0,0,0,1);
        drv(1,0,1,1,0,0,0,1);
        drv(1,0,1,0,0,0,1,1);
        check("R11 store valid during load", bit_of(10));

        // R12: kill coincides with violations, then suppression until busy drops
        do_reset();
        drv(1,0,1,0,0,0,0,1);
        kill = 1;
        drv(1,0,1,1,1,0,0,1);
        kill = 0;
        drv(1,1,1,0,0,0,0,1);
        drv(0,0,0,0,0,0,0,0);
        check("R12 violations suppressed by kill", '0);
        legal_txn(0, 0, 16'h0040, 1, 1, 1);
        check("R12 clean transaction after kill", '0);
        drv(1,0,0,0,0,0,0,0);
        check("R12 tracking resumes", bit_of(2));

        quiet();
        tick(); tick(); tick();
        check("R13 flag sticky", bit_of(2));
        do_reset();
        check("R13 reset clears flags", '0);

        // Constrained-random legal traffic
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 300; n++) begin
            bit st;
            bit ex;
            st = ($urandom % 2) == 1;
            ex = ($urandom % 5) == 0;
            legal_txn(st, ex, AW'($urandom), int'($urandom % 3),
                      int'($urandom % 3), int'($urandom % 4));
            quiet();
            for (int g = 0; g < int'($urandom % 3); g++) tick();
            if (n % 30 == 29)
                check("R3 R8 R9 R10 random legal traffic", '0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule